// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits beside one processor core and arbitrates among 256 interrupt vectors. It records which vectors are waiting for service and which are being serviced. For each vector it also keeps a flag saying whether the last post of that vector was level-triggered or edge-triggered. A vector number carries its own priority: a larger number wins. The upper nibble of the number gives a 16-level priority class.

Sources post a vector with a trigger flag. The controller works out a processor priority from a programmable task priority and the class of the highest vector in service. It raises a request line to the core when a waiting vector outranks that priority. The core answers with an acknowledge pulse. One cycle later the controller returns either the granted vector or a spurious vector. When the handler finishes, the core issues an end-of-interrupt pulse, which retires the highest vector in service.

A small register port reads and writes the task priority and the spurious/enable register. The same port also reads back the processor priority.

Top module: `irq_prio_ctrl`

## Requirements
- R1: When several vectors are waiting, a granted acknowledge returns the highest-numbered one.
- R2: The processor priority (read with selector 2) equals the task priority when the task priority's upper nibble is at least the class (vector bits 7:4) of the highest in-service vector; otherwise it equals that class followed by four zero bits. With nothing in service, the class counts as 0.
- R3: The request line is high only when bit 8 of the spurious register is set and some vector is waiting. When the processor priority is non-zero, the waiting vector's class must also be strictly above the processor priority's class.
- R4: If the controller is enabled and a vector is waiting, but the task priority is non-zero and the highest waiting vector is less than or equal to it, an acknowledge returns bits 7:0 of the spurious register with the empty flag low. Neither the waiting set nor the in-service set changes.
- R5: Otherwise a granted acknowledge clears the highest waiting bit and sets the same bit in service. The vector appears on the response outputs, with the response valid pulse, in the cycle after the acknowledge.
- R6: An end-of-interrupt pulse clears only the highest in-service bit. With nothing in service it has no effect.
- R7: A post sets the vector's waiting bit and stores its trigger flag (1 = level, 0 = edge), overwriting the flag of an earlier post. A grant reports the stored flag on the response level output.
- R8: The spurious register (selector 1) keeps bits 8:0 of a write and resets to 0x0FF, so the controller starts disabled. The task priority (selector 0) keeps bits 7:0 and resets to 0. Selector 3 reads 0.
- R9: The request line reflects any post, acknowledge, end-of-interrupt or register write from the cycle that follows it.
- R10: An acknowledge while the controller is disabled, or with nothing waiting, returns bits 7:0 of the spurious register with the empty flag high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| post_valid | input | 1 | Post a vector this cycle |
| post_vector | input | 8 | Vector being posted |
| post_level | input | 1 | 1 = level-triggered post, 0 = edge |
| ack_req | input | 1 | Core acknowledge pulse |
| eoi_req | input | 1 | End-of-interrupt pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 task priority, 1 spurious, 2 processor priority (read only), 3 none |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_sel, combinational |
| irq_out | output | 1 | Interrupt request to the core |
| ack_valid | output | 1 | One-cycle pulse: response is ready |
| ack_vector | output | 8 | Granted or spurious vector |
| ack_empty | output | 1 | Response carries no vector (disabled or nothing waiting) |
| ack_level | output | 1 | Trigger flag of the granted vector |

## Verification
A lost or stuck waiting bit shows one cycle later. The request line fails to rise, or stays high when it should fall, and the next acknowledge returns the wrong vector or a spurious one. A wrong in-service bit shows at once in the processor priority read. It also shows in the request line, which becomes masked or unmasked against lower classes. End-of-interrupt sequences then retire the wrong vector, and the processor priority readback exposes that in the cycle after the pulse.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;

    typedef enum logic [1:0] {
        SEL_TASK = 2'd0,
        SEL_SPUR = 2'd1,
        SEL_PROC = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACK_GRANT   = 2'd0,
        ACK_BLOCKED = 2'd1,
        ACK_EMPTY   = 2'd2
    } ack_kind_e;

endpackage

// File: rtl/irq_prio_find_top.sv
module irq_prio_find_top #(
    parameter int N   = 256,
    parameter int GRP = 16
) (
    input  logic [N-1:0]         bits,
    output logic                 any,
    output logic [$clog2(N)-1:0] idx
);
    localparam int IW = $clog2(N);
    localparam int NG = N / GRP;
    localparam int GW = $clog2(GRP);

    logic [NG-1:0]    grp_any;
    logic [NG*GW-1:0] grp_idx;

    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GW-1:0] loc;
        always_comb begin
            loc = '0;
            for (int b = 0; b < GRP; b++) begin
                if (bits[g*GRP + b]) loc = GW'(b);
            end
        end
        assign grp_any[g]              = |bits[g*GRP +: GRP];
        assign grp_idx[g*GW +: GW]     = loc;
    end

    always_comb begin
        any = |grp_any;
        idx = '0;
        for (int g = 0; g < NG; g++) begin
            if (grp_any[g]) idx = IW'(g * GRP) + IW'(grp_idx[g*GW +: GW]);
        end
    end
endmodule

// File: rtl/irq_prio_regs.sv
module irq_prio_regs
    import irq_prio_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [1:0]        sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [VEC_W-1:0]  tpr_q,
    output logic [VEC_W:0]    spur_q
);
    localparam logic [VEC_W:0] SPUR_RST = {1'b0, {VEC_W{1'b1}}};

    typedef struct packed {
        logic [VEC_W-1:0] tpr;
        logic [VEC_W:0]   spur;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            case (reg_sel_e'(sel))
                SEL_TASK: r_d.tpr  = wdata[VEC_W-1:0];
                SEL_SPUR: r_d.spur = wdata[VEC_W:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.tpr  <= '0;
            r_q.spur <= SPUR_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign tpr_q  = r_q.tpr;
    assign spur_q = r_q.spur;

    // R8
    spur_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd1) |=> spur_q == $past(wdata[VEC_W:0]));

    // R8
    task_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == 2'd0) |=> tpr_q == $past(wdata[VEC_W-1:0]));
endmodule

// File: rtl/irq_prio_eval.sv
module irq_prio_eval
    import irq_prio_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  logic [VEC_W-1:0] tpr,
    input  logic [VEC_W:0]   spur,
    input  logic             irr_any,
    input  logic [VEC_W-1:0] irr_top,
    input  logic             isr_any,
    input  logic [VEC_W-1:0] isr_top,
    output logic [VEC_W-1:0] ppr,
    output logic             irq_line,
    output ack_kind_e        ack_kind
);
    localparam int CLS_W = VEC_W - 4;

    logic [CLS_W-1:0] svc_cls;
    logic             sw_en;

    always_comb begin
        sw_en   = spur[VEC_W];
        svc_cls = isr_any ? isr_top[VEC_W-1:4] : '0;
        if (tpr[VEC_W-1:4] >= svc_cls) ppr = tpr;
        else                           ppr = {svc_cls, 4'h0};

        irq_line = sw_en && irr_any &&
                   ((ppr == '0) || (irr_top[VEC_W-1:4] > ppr[VEC_W-1:4]));

        if (!sw_en || !irr_any)                 ack_kind = ACK_EMPTY;
        else if (tpr != '0 && irr_top <= tpr)   ack_kind = ACK_BLOCKED;
        else                                    ack_kind = ACK_GRANT;
    end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
    import irq_prio_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int DATA_W = 32,
    parameter int GRP    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              post_valid,
    input  logic [VEC_W-1:0]  post_vector,
    input  logic              post_level,
    input  logic              ack_req,
    input  logic              eoi_req,
    input  logic              reg_wr,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_out,
    output logic              ack_valid,
    output logic [VEC_W-1:0]  ack_vector,
    output logic              ack_empty,
    output logic              ack_level
);
    localparam int NUM_VEC = 1 << VEC_W;

    typedef struct packed {
        logic [NUM_VEC-1:0] irr;
        logic [NUM_VEC-1:0] isr;
        logic [NUM_VEC-1:0] tmr;
        logic               rsp_valid;
        logic [VEC_W-1:0]   rsp_vec;
        logic               rsp_empty;
        logic               rsp_level;
    } state_t;

    state_t s_d, s_q;

    logic [VEC_W-1:0] tpr_q;
    logic [VEC_W:0]   spur_q;
    logic             irr_any, isr_any;
    logic [VEC_W-1:0] irr_top, isr_top;
    logic [VEC_W-1:0] ppr;
    logic             irq_line;
    ack_kind_e        ack_kind;

    irq_prio_regs #(.VEC_W(VEC_W), .DATA_W(DATA_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (reg_wr),
        .sel    (reg_sel),
        .wdata  (reg_wdata),
        .tpr_q  (tpr_q),
        .spur_q (spur_q)
    );

    irq_prio_find_top #(.N(NUM_VEC), .GRP(GRP)) u_find_irr (
        .bits (s_q.irr),
        .any  (irr_any),
        .idx  (irr_top)
    );

    irq_prio_find_top #(.N(NUM_VEC), .GRP(GRP)) u_find_isr (
        .bits (s_q.isr),
        .any  (isr_any),
        .idx  (isr_top)
    );

    irq_prio_eval #(.VEC_W(VEC_W)) u_eval (
        .tpr      (tpr_q),
        .spur     (spur_q),
        .irr_any  (irr_any),
        .irr_top  (irr_top),
        .isr_any  (isr_any),
        .isr_top  (isr_top),
        .ppr      (ppr),
        .irq_line (irq_line),
        .ack_kind (ack_kind)
    );

    always_comb begin
        s_d           = s_q;
        s_d.rsp_valid = 1'b0;

        if (eoi_req && isr_any) s_d.isr[isr_top] = 1'b0;

        if (ack_req) begin
            s_d.rsp_valid = 1'b1;
            case (ack_kind)
                ACK_GRANT: begin
                    s_d.irr[irr_top] = 1'b0;
                    s_d.isr[irr_top] = 1'b1;
                    s_d.rsp_vec      = irr_top;
                    s_d.rsp_empty    = 1'b0;
                    s_d.rsp_level    = s_q.tmr[irr_top];
                end
                ACK_BLOCKED: begin
                    s_d.rsp_vec   = spur_q[VEC_W-1:0];
                    s_d.rsp_empty = 1'b0;
                    s_d.rsp_level = 1'b0;
                end
                default: begin
                    s_d.rsp_vec   = spur_q[VEC_W-1:0];
                    s_d.rsp_empty = 1'b1;
                    s_d.rsp_level = 1'b0;
                end
            endcase
        end

        if (post_valid) begin
            s_d.irr[post_vector] = 1'b1;
            s_d.tmr[post_vector] = post_level;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (reg_sel_e'(reg_sel))
            SEL_TASK: reg_rdata = DATA_W'(tpr_q);
            SEL_SPUR: reg_rdata = DATA_W'(spur_q);
            SEL_PROC: reg_rdata = DATA_W'(ppr);
            default:  reg_rdata = '0;
        endcase
    end

    assign irq_out    = irq_line;
    assign ack_valid  = s_q.rsp_valid;
    assign ack_vector = s_q.rsp_vec;
    assign ack_empty  = s_q.rsp_empty;
    assign ack_level  = s_q.rsp_level;

    // R5
    grant_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_kind == ACK_GRANT && !eoi_req)
        |=> ack_valid && !ack_empty && s_q.isr[ack_vector]);

    // R4
    blocked_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && ack_kind == ACK_BLOCKED && !post_valid && !eoi_req)
        |=> $stable(s_q.irr) && $stable(s_q.isr) && !ack_empty);

    // R7
    post_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid |=> s_q.irr[$past(post_vector)] &&
                       (s_q.tmr[$past(post_vector)] == $past(post_level)));

    // R3
    irq_needs_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> spur_q[VEC_W] && (s_q.irr != '0));

    // R6
    eoi_retires_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_req && !ack_req && isr_any) |=> !s_q.isr[$past(isr_top)]);

    // R10
    empty_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_req && (s_q.irr == '0)) |=> ack_valid && ack_empty);

    // R2
    ppr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ppr[VEC_W-1:4] >= tpr_q[VEC_W-1:4]);
endmodule

// File: tb/irq_prio_ctrl_bench.sv
module irq_prio_ctrl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        post_valid = 1'b0;
    logic [7:0]  post_vector = '0;
    logic        post_level = 1'b0;
    logic        ack_req = 1'b0;
    logic        eoi_req = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out, ack_valid, ack_empty, ack_level;
    logic [7:0]  ack_vector;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n),
        .post_valid(post_valid), .post_vector(post_vector), .post_level(post_level),
        .ack_req(ack_req), .eoi_req(eoi_req),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .ack_valid(ack_valid), .ack_vector(ack_vector),
        .ack_empty(ack_empty), .ack_level(ack_level)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_reg(logic [1:0] sel, logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        step();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(logic [1:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic post(logic [7:0] v, logic lvl);
        post_valid = 1'b1; post_vector = v; post_level = lvl;
        step();
        post_valid = 1'b0;
    endtask

    task automatic ack(string req, logic [7:0] exp_v, logic exp_empty, logic exp_lvl);
        ack_req = 1'b1;
        step();
        ack_req = 1'b0;
        check({req, " ack valid"}, 32'(ack_valid), 32'd1);
        check({req, " ack vector"}, 32'(ack_vector), 32'(exp_v));
        check({req, " ack empty"}, 32'(ack_empty), 32'(exp_empty));
        check({req, " ack level"}, 32'(ack_level), 32'(exp_lvl));
    endtask

    task automatic eoi();
        eoi_req = 1'b1;
        step();
        eoi_req = 1'b0;
    endtask

    task automatic check_ppr(string req, logic [7:0] exp);
        logic [31:0] d;
        rd_reg(2'd2, d);
        check({req, " processor priority"}, d, 32'(exp));
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R8 reset irq", 32'(irq_out), 32'd0);
        rd_reg(2'd0, d); check("R8 reset task priority", d, 32'h0);
        rd_reg(2'd1, d); check("R8 reset spurious", d, 32'h0FF);
        rd_reg(2'd3, d); check("R8 unused selector", d, 32'h0);
        check_ppr("R2 reset", 8'h00);
    endtask

    task automatic t_regs();
        logic [31:0] d;
        wr_reg(2'd1, 32'hFFFF_F1AB);
        rd_reg(2'd1, d); check("R8 spurious keeps 9 bits", d, 32'h1AB);
        wr_reg(2'd0, 32'h0000_1234);
        rd_reg(2'd0, d); check("R8 task keeps 8 bits", d, 32'h34);
        check_ppr("R2 task only", 8'h34);
        wr_reg(2'd0, 32'h0);
        wr_reg(2'd1, 32'h0FF);
    endtask

    task automatic t_disabled();
        post(8'h40, 1'b0);
        check("R3 disabled irq", 32'(irq_out), 32'd0);
        ack("R10 disabled", 8'hFF, 1'b1, 1'b0);
        wr_reg(2'd1, 32'h1F0);
        check("R9 irq after enable", 32'(irq_out), 32'd1);
    endtask

    task automatic t_order();
        post(8'h41, 1'b0);
        post(8'h90, 1'b1);
        check("R9 irq after post", 32'(irq_out), 32'd1);
        ack("R1 R5 R7 highest level", 8'h90, 1'b0, 1'b1);
        check("R3 lower class masked", 32'(irq_out), 32'd0);
        check_ppr("R2 service class", 8'h90);
        eoi();
        check("R9 irq after eoi", 32'(irq_out), 32'd1);
        check_ppr("R6 after eoi", 8'h00);
        ack("R7 edge", 8'h41, 1'b0, 1'b0);
        check("R3 same class masked", 32'(irq_out), 32'd0);
        ack("R1 next", 8'h40, 1'b0, 1'b0);
        check_ppr("R2 two in service", 8'h40);
        eoi();
        check_ppr("R6 highest retired", 8'h40);
        eoi();
        check_ppr("R6 last retired", 8'h00);
        eoi();
        check_ppr("R6 eoi with nothing", 8'h00);
        check("R6 eoi with nothing irq", 32'(irq_out), 32'd0);
        ack("R10 nothing waiting", 8'hF0, 1'b1, 1'b0);
    endtask

    task automatic t_task_block();
        wr_reg(2'd0, 32'h50);
        check_ppr("R2 task priority", 8'h50);
        post(8'h50, 1'b0);
        check("R3 class not above", 32'(irq_out), 32'd0);
        ack("R4 equal blocked", 8'hF0, 1'b0, 1'b0);
        post(8'h61, 1'b0);
        check("R3 class above", 32'(irq_out), 32'd1);
        ack("R5 above task", 8'h61, 1'b0, 1'b0);
        ack("R4 still blocked", 8'hF0, 1'b0, 1'b0);
        wr_reg(2'd0, 32'h0);
        check_ppr("R2 service over task", 8'h60);
        check("R3 masked by service", 32'(irq_out), 32'd0);
        eoi();
        check("R4 waiting kept", 32'(irq_out), 32'd1);
        ack("R4 kept vector", 8'h50, 1'b0, 1'b0);
        eoi();
        ack("R10 empty", 8'hF0, 1'b1, 1'b0);
    endtask

    task automatic t_trigger();
        wr_reg(2'd1, 32'h0F0);
        post(8'h33, 1'b1);
        check("R3 disabled with work", 32'(irq_out), 32'd0);
        wr_reg(2'd1, 32'h1F0);
        check("R9 re-enabled", 32'(irq_out), 32'd1);
        post(8'h70, 1'b0);
        post(8'h70, 1'b1);
        ack("R7 flag overwritten", 8'h70, 1'b0, 1'b1);
        ack("R7 lower level", 8'h33, 1'b0, 1'b1);
        eoi();
        eoi();
        check_ppr("R6 all retired", 8'h00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_regs();
        t_disabled();
        t_order();
        t_task_block();
        t_trigger();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule